// File: doc/BRIEF.md
# Dual-Channel Synchronous Serial Unit

This block moves fixed 16-bit words over a pair of independent synchronous serial links, one outbound and one inbound. Each direction has its own enable, its own serial clock and its own choice of clock ownership. In master mode a channel produces its serial clock from a shared prescaler. In slave mode it follows a clock that arrives from outside. Because the two directions never share a bit counter or a clock, a word can be sent while an unrelated word is being received at a different rate.

The shared prescaler emits a tick every `baud_div + 1` system cycles. That tick stream runs at twice the bit rate: a master serial clock toggles once per tick. Each direction has two buffer stages, a holding register seen by the host and a shift register attached to the line. Software can therefore stage the next outbound word while the current one is still on the wire, and an inbound word stays readable while the following one is being assembled. The host sees an empty/full status for each direction, an overflow flag on receive, and one interrupt request per direction that passes only when that direction's interrupt enable is set.

Serial clocks idle low. Outbound data changes on falling edges and inbound data is captured on rising edges, most significant bit first. External clocks pass through a two-stage synchronizer before use.

Top module: `sync_serial_unit`

## Requirements
- R1: After reset, tx_empty=1, rx_full=0, rx_ovf=0, and tx_sclk_out, rx_sclk_out and tx_sd are all 0.
- R2: A master serial clock idles low and toggles on every prescaler tick, so one bit period lasts 2*(baud_div+1) clk cycles.
- R3: A word is sent most significant bit first. tx_sd shows bit 15 as soon as the word enters the shift register and changes only on falling serial clock edges. The receiver captures on rising edges, so a transmitter looped back into a receiver delivers the same 16-bit value.
- R4: The transmit holding register empties (tx_empty=1) when its word moves into an idle shift register. A word loaded while another is shifting follows it with no idle bit time.
- R5: A tx_load pulse while tx_empty=0 is ignored. The held word is kept and the discarded value is never sent.
- R6: While tx_en=0 no word moves out of the holding register and tx_sclk_out stays 0. Clearing tx_en in the middle of a word abandons that word.
- R7: A master transmitter with no word pending stops its clock low after the last bit.
- R8: After 16 captured bits, rx_data holds the word (first captured bit in bit 15) and rx_full=1. An rx_read pulse clears rx_full and rx_ovf.
- R9: If a word completes while rx_full=1 and no read occurs in that cycle, rx_ovf becomes 1 and rx_data takes the newer word.
- R10: In slave mode a channel drives no clock (its sclk_out stays 0). A slave transmitter shifts on falling edges of tx_sclk_in, and a slave receiver captures on rising edges of rx_sclk_in. External half periods must be at least 4 clk cycles.
- R11: A master receiver runs its clock for as long as rx_en=1 and captures rx_sd on each rising edge it produces. This lets it pull a word from a slave transmitter.
- R12: tx_irq = tx_irq_en AND tx_empty, and rx_irq = rx_irq_en AND rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Prescaler divisor; tick every baud_div+1 cycles |
| tx_en | input | 1 | Transmit enable |
| tx_master | input | 1 | 1: transmitter drives its clock; 0: follows tx_sclk_in |
| tx_irq_en | input | 1 | Gate for tx_irq |
| tx_load | input | 1 | Write pulse for the transmit holding register |
| tx_data | input | WORD_W | Word to transmit |
| tx_empty | output | 1 | Transmit holding register can accept a word |
| tx_irq | output | 1 | Gated transmit interrupt request |
| tx_sclk_in | input | 1 | External transmit clock (slave mode) |
| tx_sclk_out | output | 1 | Generated transmit clock (master mode) |
| tx_sd | output | 1 | Serial transmit data |
| rx_en | input | 1 | Receive enable |
| rx_master | input | 1 | 1: receiver drives its clock; 0: follows rx_sclk_in |
| rx_irq_en | input | 1 | Gate for rx_irq |
| rx_read | input | 1 | Read acknowledge pulse for rx_data |
| rx_data | output | WORD_W | Last received word |
| rx_full | output | 1 | Receive holding register holds an unread word |
| rx_ovf | output | 1 | A word arrived while the previous was unread |
| rx_irq | output | 1 | Gated receive interrupt request |
| rx_sclk_in | input | 1 | External receive clock (slave mode) |
| rx_sclk_out | output | 1 | Generated receive clock (master mode) |
| rx_sd | input | 1 | Serial receive data |

## Verification
The bench builds the unit with its defaults, WORD_W=16 and DIV_W=8, and feeds transmit data and clock back into the receiver. It varies baud_div between 3 and 9. That keeps each word within a few hundred cycles, so back-to-back streams, overflow and both clock-ownership arrangements fit in one short run. The lower end of that range also drives the synchronized slave paths at their tightest legal half period, where a one-cycle capture slip would corrupt a bit.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
    typedef enum logic {
        SSU_EDGE_RISE = 1'b0,
        SSU_EDGE_FALL = 1'b1
    } ssu_edge_e;
endpackage

// File: rtl/ssu_baud_gen.sv
module ssu_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssu_edge_sync.sv
module ssu_edge_sync
    import ssu_pkg::*;
#(
    parameter ssu_edge_e KIND = SSU_EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    logic [2:0] sync_d, sync_q;

    always_comb sync_d = {sync_q[1:0], pin};

    generate
        if (KIND == SSU_EDGE_RISE) begin : g_rise
            assign pulse = sync_q[1] & ~sync_q[2];
        end else begin : g_fall
            assign pulse = ~sync_q[1] & sync_q[2];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/ssu_tx_chan.sv
module ssu_tx_chan #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              tick,
    input  logic              ext_fall,
    input  logic              load,
    input  logic [WORD_W-1:0] data,
    output logic              empty,
    output logic              sclk,
    output logic              sd
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              hold_vld;
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  left;
        logic              active;
        logic              sclk;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      fall_ev;
    logic      last_bit;

    always_comb begin
        s_d      = s_q;
        fall_ev  = master ? (s_q.active & tick & s_q.sclk) : (s_q.active & ext_fall);
        last_bit = fall_ev && (s_q.left == CNT_W'(1));

        if (master && s_q.active && tick) s_d.sclk = ~s_q.sclk;

        if (load && !s_q.hold_vld) begin
            s_d.hold     = data;
            s_d.hold_vld = 1'b1;
        end

        if (fall_ev) begin
            s_d.shift = {s_q.shift[WORD_W-2:0], 1'b0};
            s_d.left  = s_q.left - 1'b1;
            if (last_bit) s_d.active = 1'b0;
        end

        if (s_q.hold_vld && (!s_q.active || last_bit)) begin
            s_d.shift    = s_q.hold;
            s_d.left     = CNT_W'(WORD_W);
            s_d.active   = 1'b1;
            s_d.hold_vld = 1'b0;
        end

        if (!master) s_d.sclk = 1'b0;

        if (!en) begin
            s_d.hold_vld = s_q.hold_vld | (load & !s_q.hold_vld);
            s_d.active   = 1'b0;
            s_d.sclk     = 1'b0;
            s_d.shift    = '0;
            s_d.left     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign empty = ~s_q.hold_vld;
    assign sclk  = s_q.sclk;
    assign sd    = s_q.shift[WORD_W-1];
endmodule

// File: rtl/ssu_rx_chan.sv
module ssu_rx_chan #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              tick,
    input  logic              ext_rise,
    input  logic              sd,
    input  logic              rd,
    output logic [WORD_W-1:0] data,
    output logic              full,
    output logic              ovf,
    output logic              sclk
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  got;
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              ovf;
        logic              sclk;
    } rx_state_t;

    rx_state_t         s_d, s_q;
    logic              rise_ev;
    logic              done;
    logic [WORD_W-1:0] next_shift;

    always_comb begin
        s_d        = s_q;
        done       = 1'b0;
        rise_ev    = en && (master ? (tick & ~s_q.sclk) : ext_rise);
        next_shift = {s_q.shift[WORD_W-2:0], sd};

        if (master && en && tick) s_d.sclk = ~s_q.sclk;
        if (!master || !en)       s_d.sclk = 1'b0;

        if (rise_ev) begin
            s_d.shift = next_shift;
            if (s_q.got == CNT_W'(WORD_W - 1)) begin
                done     = 1'b1;
                s_d.got  = '0;
                s_d.hold = next_shift;
            end else begin
                s_d.got = s_q.got + 1'b1;
            end
        end

        if (!en) s_d.got = '0;

        s_d.full = (s_q.full & ~rd) | done;
        s_d.ovf  = (s_q.ovf & ~rd) | (done & s_q.full & ~rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data = s_q.hold;
    assign full = s_q.full;
    assign ovf  = s_q.ovf;
    assign sclk = s_q.sclk;
endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit
    import ssu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              tx_en,
    input  logic              tx_master,
    input  logic              tx_irq_en,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_irq,
    input  logic              tx_sclk_in,
    output logic              tx_sclk_out,
    output logic              tx_sd,
    input  logic              rx_en,
    input  logic              rx_master,
    input  logic              rx_irq_en,
    input  logic              rx_read,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              rx_irq,
    input  logic              rx_sclk_in,
    output logic              rx_sclk_out,
    input  logic              rx_sd
);
    logic tick;
    logic tx_ext_fall;
    logic rx_ext_rise;

    ssu_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    ssu_edge_sync #(.KIND(SSU_EDGE_FALL)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .pin(tx_sclk_in), .pulse(tx_ext_fall)
    );

    ssu_edge_sync #(.KIND(SSU_EDGE_RISE)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .pin(rx_sclk_in), .pulse(rx_ext_rise)
    );

    ssu_tx_chan #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .master(tx_master),
        .tick(tick), .ext_fall(tx_ext_fall), .load(tx_load), .data(tx_data),
        .empty(tx_empty), .sclk(tx_sclk_out), .sd(tx_sd)
    );

    ssu_rx_chan #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .master(rx_master),
        .tick(tick), .ext_rise(rx_ext_rise), .sd(rx_sd), .rd(rx_read),
        .data(rx_data), .full(rx_full), .ovf(rx_ovf), .sclk(rx_sclk_out)
    );

    assign tx_irq = tx_irq_en & tx_empty;
    assign rx_irq = rx_irq_en & rx_full;
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_sclk_out,
    input logic rx_master,
    input logic rx_sclk_out,
    input logic rx_read,
    input logic rx_full,
    input logic rx_ovf,
    input logic rx_irq_en,
    input logic rx_irq
);
    AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> rx_full); // R9

    AST_OVF_RISE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $past(rx_full)); // R9

    AST_READ_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && rx_full) |=> !rx_ovf); // R8

    AST_TX_OFF_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_sclk_out); // R6

    AST_RX_SLAVE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_master |=> !rx_sclk_out); // R10

    AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_irq_en && rx_full)); // R12
endmodule

bind sync_serial_unit ssu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_sclk_out(tx_sclk_out),
    .rx_master(rx_master), .rx_sclk_out(rx_sclk_out), .rx_read(rx_read),
    .rx_full(rx_full), .rx_ovf(rx_ovf), .rx_irq_en(rx_irq_en), .rx_irq(rx_irq)
);

// File: tb/sync_serial_unit_test.sv
module sync_serial_unit_test;
    localparam int WORD_W = 16;
    localparam int DIV_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] baud_div = 8'd3;
    logic tx_en = 0, tx_master = 1, tx_irq_en = 0, tx_load = 0;
    logic [WORD_W-1:0] tx_data = '0;
    logic tx_empty, tx_irq, tx_sclk_out, tx_sd;
    logic rx_en = 0, rx_master = 0, rx_irq_en = 0, rx_read = 0;
    logic [WORD_W-1:0] rx_data;
    logic rx_full, rx_ovf, rx_irq, rx_sclk_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sync_serial_unit #(.WORD_W(WORD_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
        .tx_en(tx_en), .tx_master(tx_master), .tx_irq_en(tx_irq_en),
        .tx_load(tx_load), .tx_data(tx_data), .tx_empty(tx_empty), .tx_irq(tx_irq),
        .tx_sclk_in(rx_sclk_out), .tx_sclk_out(tx_sclk_out), .tx_sd(tx_sd),
        .rx_en(rx_en), .rx_master(rx_master), .rx_irq_en(rx_irq_en),
        .rx_read(rx_read), .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf),
        .rx_irq(rx_irq), .rx_sclk_in(tx_sclk_out), .rx_sclk_out(rx_sclk_out),
        .rx_sd(tx_sd)
    );

    function automatic int bit_period(input int div);
        return 2 * (div + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_word(input logic [WORD_W-1:0] w);
        tx_data = w;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 4000 && !tx_empty; i++) @(negedge clk);
    endtask

    task automatic wait_full(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (rx_full) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic do_read();
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic rx_restart();
        rx_en = 1'b0;
        cyc(1);
        rx_en = 1'b1;
        cyc(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        int t0, per, hi;
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] exp_w [3];
        void'($urandom(32'd2024));

        cyc(3);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk({rx_full, rx_ovf} == 2'b00, "R1 rx flags", {rx_full, rx_ovf}, 0);
        chk({tx_sclk_out, rx_sclk_out, tx_sd} == 3'b000, "R1 lines", {tx_sclk_out, rx_sclk_out, tx_sd}, 0);
        rst_n = 1'b1;
        cyc(2);

        // R2 R3 R4: first word, master transmitter into slave receiver
        tx_en = 1'b1; rx_en = 1'b1;
        load_word(16'hA5C3);
        cyc(2);
        chk(tx_sd == 1'b1, "R3 MSB first", tx_sd, 1);
        chk(tx_empty == 1'b1, "R4 empty after move", tx_empty, 1);
        while (!tx_sclk_out) @(negedge clk);
        while (tx_sclk_out) @(negedge clk);
        t0 = 0;
        while (!tx_sclk_out) begin @(negedge clk); t0++; end
        per = t0;
        while (tx_sclk_out) begin @(negedge clk); per++; end
        chk(per == bit_period(3), "R2 bit period", per, bit_period(3));
        wait_full(ok);
        chk(ok && rx_data == 16'hA5C3, "R3 R8 loopback word", rx_data, 16'hA5C3);
        chk(rx_irq == 1'b0, "R12 rx irq gated off", rx_irq, 0);
        rx_irq_en = 1'b1;
        cyc(1);
        chk(rx_irq == 1'b1, "R12 rx irq on", rx_irq, 1);
        tx_irq_en = 1'b1;
        cyc(1);
        chk(tx_irq == 1'b1, "R12 tx irq on", tx_irq, 1);
        tx_irq_en = 1'b0; rx_irq_en = 1'b0;
        do_read();
        chk(rx_full == 1'b0, "R8 read clears full", rx_full, 0);
        hi = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (tx_sclk_out) hi++; end
        chk(hi == 0, "R7 idle clock low", hi, 0);

        // R5 R6: loads while disabled, second load ignored
        tx_en = 1'b0;
        cyc(1);
        load_word(16'h3C5A);
        chk(tx_empty == 1'b0, "R6 held while disabled", tx_empty, 0);
        load_word(16'hFFFF);
        hi = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (tx_sclk_out) hi++; end
        chk(hi == 0 && rx_full == 1'b0, "R6 no clock while disabled", hi, 0);
        rx_restart();
        tx_en = 1'b1;
        wait_full(ok);
        chk(ok && rx_data == 16'h3C5A, "R5 held word kept", rx_data, 16'h3C5A);
        do_read();
        cyc(200);
        chk(rx_full == 1'b0, "R5 ignored word not sent", rx_full, 0);

        // R6: abandon mid-word
        load_word(16'h0F0F);
        cyc(20);
        tx_en = 1'b0;
        cyc(2);
        chk(tx_sclk_out == 1'b0 && tx_sd == 1'b0, "R6 abandon word", {tx_sclk_out, tx_sd}, 0);
        tx_en = 1'b1;
        rx_restart();

        // R9: overflow
        load_word(16'h1234);
        wait_empty();
        load_word(16'hBEEF);
        for (int i = 0; i < 4000 && !rx_ovf; i++) @(negedge clk);
        chk(rx_ovf == 1'b1 && rx_full == 1'b1, "R9 overflow set", {rx_ovf, rx_full}, 3);
        chk(rx_data == 16'hBEEF, "R9 newer word kept", rx_data, 16'hBEEF);
        do_read();
        chk({rx_ovf, rx_full} == 2'b00, "R8 read clears ovf", {rx_ovf, rx_full}, 0);

        // R4: random back-to-back streams at varied rates
        for (int it = 0; it < 6; it++) begin
            baud_div = 8'($urandom_range(3, 9));
            for (int k = 0; k < 3; k++) exp_w[k] = 16'($urandom);
            cyc(bit_period(9) * 2);
            rx_restart();
            fork
                begin
                    for (int k = 0; k < 3; k++) begin
                        wait_empty();
                        load_word(exp_w[k]);
                    end
                end
                begin
                    for (int k = 0; k < 3; k++) begin
                        wait_full(ok);
                        chk(ok && rx_data == exp_w[k], "R4 stream word", rx_data, exp_w[k]);
                        do_read();
                    end
                end
            join
        end

        // R10 R11: slave transmitter, master receiver
        cyc(bit_period(9) * 2);
        baud_div = 8'd4;
        tx_en = 1'b0; rx_en = 1'b0;
        cyc(2);
        tx_master = 1'b0; rx_master = 1'b1;
        tx_en = 1'b1;
        w = 16'h9D61;
        load_word(w);
        cyc(3);
        chk(tx_empty == 1'b1 && tx_sclk_out == 1'b0, "R10 slave tx waits, no clock", {tx_empty, tx_sclk_out}, 2);
        rx_en = 1'b1;
        wait_full(ok);
        rx_en = 1'b0;
        chk(ok && rx_data == w, "R11 master rx pulls word", rx_data, w);
        do_read();
        cyc(4);
        chk(rx_sclk_out == 1'b0, "R11 clock stops when disabled", rx_sclk_out, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule